// File: doc/BRIEF.md
# Degree-One Base-Case Modular Multiplier

This block multiplies two degree-one polynomials, (a0 + a1·X) and (b0 + b1·X), modulo (X² − zeta) over the prime field of order q = 3329. It serves as the arithmetic core of pointwise multiplication between transform-domain polynomials. A surrounding sequencer feeds it one coefficient pair per call. a0 and b0 are the coefficients at even index 2k. a1 and b1 are the coefficients at odd index 2k+1. zeta is the twiddle value selected for pair index k; 128 distinct values cover 256 coefficients. Coefficient storage, the twiddle table and address sequencing stay with the caller.

Every product is reduced with Barrett reduction, using the constant floor(2^24 / q) = 5039 on products of up to 24 bits. A single conditional subtraction follows, so each result is fully reduced. The datapath is pipelined into two register stages. A pair presented with `valid_in` returns as (c0, c1) with `valid_out` exactly two clock cycles later. A new pair can be accepted on every cycle. All inputs are assumed to be already reduced into 0..q−1. Results must agree bit for bit with an integer software model.

Top module: `bcm_basecase_mul`

## Requirements
- R1: c0 equals (a0·b0 + ((a1·b1 mod q)·zeta)) mod q, with q = 3329.
- R2: c1 equals (a0·b1 + a1·b0) mod q.
- R3: c0 and c1 are always within 0..q−1 when `valid_out` is high. With every input at q−1 (3328), the results are c0 = 0 and c1 = 2.
- R4: `valid_out` is high in exactly the cycle that follows two rising edges after a cycle in which `valid_in` was high, and low otherwise.
- R5: Pairs presented on consecutive cycles are all accepted. Each result appears in order, one per cycle, with correct values.
- R6: While `valid_out` is low, c0 and c1 hold the values of the last valid result.
- R7: While `rst_n` is low at a rising edge, the next cycle shows `valid_out` = 0, c0 = 0 and c1 = 0.
- R8: With zeta = 1, c0 equals (a0·b0 + a1·b1) mod q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Marks the pair on the operand inputs as valid |
| a0 | input | 12 | First operand, even-index coefficient |
| a1 | input | 12 | First operand, odd-index coefficient |
| b0 | input | 12 | Second operand, even-index coefficient |
| b1 | input | 12 | Second operand, odd-index coefficient |
| zeta | input | 12 | Twiddle value for this pair |
| valid_out | output | 1 | Marks c0 and c1 as a new result |
| c0 | output | 12 | Reduced constant term of the product |
| c1 | output | 12 | Reduced linear term of the product |

## Verification
Four properties are checked on every cycle:
- the range of both outputs whenever a result is flagged valid;
- the two-cycle relation between `valid_in` and `valid_out`;
- the holding of the outputs through idle cycles;
- the cleared state after reset.

The arithmetic itself can only be shown by the bench's scenarios. These compare c0 and c1 against an integer model for all-zero operands, all operands at q−1, zeta = 1, hand-worked pairs, and random pairs. The random pairs are streamed both back to back and with gaps.

// File: rtl/bcm_pkg.sv
// Package: shared constants and helpers for the base-case modular multiplier.
// Assumes the modulus is an odd prime below 2^W and that the
// Barrett shift equals twice the coefficient width.
package bcm_pkg;
    localparam int unsigned DEF_Q = 3329;
    localparam int unsigned DEF_W = 12;

    // Barrett multiplier constant floor(2^sh / q)
    function automatic int unsigned barrett_const(int unsigned q, int unsigned sh);
        return (32'd1 << sh) / q;
    endfunction
endpackage

// File: rtl/bcm_barrett.sv
// Module: bcm_barrett
// Combinational Barrett reduction of a value below 2^(2W) to 0..Q-1.
// Assumes x < 2^(2W); the quotient estimate is then at most 1 short, so
// the remainder lies below 2Q and one conditional subtraction suffices.
module bcm_barrett
    import bcm_pkg::*;
#(
    parameter int unsigned Q = DEF_Q,
    parameter int unsigned W = DEF_W
) (
    input  logic [2*W-1:0] x,
    output logic [W-1:0]   r
);
    localparam int unsigned SH = 2 * W;
    localparam int unsigned M  = barrett_const(Q, SH);
    localparam int unsigned MW = $clog2(M + 1);
    localparam int unsigned PW = SH + MW;
    localparam logic [PW-1:0] M_P = PW'(M);
    localparam logic [SH-1:0] Q_S = SH'(Q);

    logic [PW-1:0] prod;
    logic [MW-1:0] qest;
    logic [SH-1:0] qmul;
    logic [SH-1:0] rem;
    logic [SH-1:0] fixed;

    // Quotient estimate, remainder, and final correction
    always_comb begin
        prod  = PW'(x) * M_P;
        qest  = MW'(prod >> SH);
        qmul  = SH'(qest) * Q_S;
        rem   = x - qmul;
        fixed = (rem >= Q_S) ? (rem - Q_S) : rem;
        r     = W'(fixed);
    end
endmodule

// File: rtl/bcm_modadd.sv
// Module: bcm_modadd
// Combinational modular addition of two values already in 0..Q-1.
module bcm_modadd
    import bcm_pkg::*;
#(
    parameter int unsigned Q = DEF_Q,
    parameter int unsigned W = DEF_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam logic [W:0] Q_E = (W+1)'(Q);

    logic [W:0] sum;

    // Add, then subtract Q once if the sum reached it
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        s   = W'((sum >= Q_E) ? (sum - Q_E) : sum);
    end
endmodule

// File: rtl/bcm_basecase_mul.sv
// Module: bcm_basecase_mul (top)
// Two-stage pipelined product of (a0 + a1 X)(b0 + b1 X) mod (X^2 - zeta), mod Q.
// Stage 1 reduces the four partial products and forms the cross sum.
// Stage 2 multiplies the reduced odd product by zeta, reduces it, and
// adds the even product. Assumes every input already lies in 0..Q-1.
// Result registers load only for valid pairs and hold otherwise.
module bcm_basecase_mul
    import bcm_pkg::*;
#(
    parameter int unsigned Q = DEF_Q,
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [W-1:0] a0,
    input  logic [W-1:0] a1,
    input  logic [W-1:0] b0,
    input  logic [W-1:0] b1,
    input  logic [W-1:0] zeta,
    output logic         valid_out,
    output logic [W-1:0] c0,
    output logic [W-1:0] c1
);
    localparam int unsigned NPROD = 4;
    localparam int unsigned W2    = 2 * W;

    // Partial product order: 0 even*even, 1 odd*odd, 2 even*odd, 3 odd*even
    logic [W-1:0] lhs [NPROD];
    logic [W-1:0] rhs [NPROD];
    logic [W-1:0] red [NPROD];

    // Operand routing for the four partial products
    always_comb begin
        lhs[0] = a0; rhs[0] = b0;
        lhs[1] = a1; rhs[1] = b1;
        lhs[2] = a0; rhs[2] = b1;
        lhs[3] = a1; rhs[3] = b0;
    end

    for (genvar g = 0; g < NPROD; g++) begin : g_prod
        logic [W2-1:0] full;
        assign full = W2'(lhs[g]) * W2'(rhs[g]);
        bcm_barrett #(.Q(Q), .W(W)) u_red (.x(full), .r(red[g]));
    end

    logic [W-1:0] cross_sum;
    bcm_modadd #(.Q(Q), .W(W)) u_cross (.a(red[2]), .b(red[3]), .s(cross_sum));

    logic         s1_v;
    logic [W-1:0] s1_even;
    logic [W-1:0] s1_odd;
    logic [W-1:0] s1_cross;
    logic [W-1:0] s1_zeta;

    // Stage 1 registers: reduced products and the twiddle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_even  <= '0;
            s1_odd   <= '0;
            s1_cross <= '0;
            s1_zeta  <= '0;
        end else begin
            s1_v <= valid_in;
            if (valid_in) begin
                s1_even  <= red[0];
                s1_odd   <= red[1];
                s1_cross <= cross_sum;
                s1_zeta  <= zeta;
            end
        end
    end

    logic [W2-1:0] tw_full;
    logic [W-1:0]  tw_red;
    logic [W-1:0]  c0_next;

    assign tw_full = W2'(s1_odd) * W2'(s1_zeta);
    bcm_barrett #(.Q(Q), .W(W)) u_tw_red (.x(tw_full), .r(tw_red));
    bcm_modadd  #(.Q(Q), .W(W)) u_c0_add (.a(s1_even), .b(tw_red), .s(c0_next));

    // Stage 2 registers: final results and their valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            c0        <= '0;
            c1        <= '0;
        end else begin
            valid_out <= s1_v;
            if (s1_v) begin
                c0 <= c0_next;
                c1 <= s1_cross;
            end
        end
    end
endmodule

// File: rtl/bcm_basecase_mul_chk.sv
// Module: bcm_basecase_mul_chk
// Checker bound to the top: output range, latency, hold and reset behaviour.
module bcm_basecase_mul_chk
    import bcm_pkg::*;
#(
    parameter int unsigned Q = DEF_Q,
    parameter int unsigned W = DEF_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_in,
    input logic         valid_out,
    input logic [W-1:0] c0,
    input logic [W-1:0] c1
);
    localparam logic [W-1:0] Q_W = W'(Q);

    logic [1:0] since_rst;

    // Count cycles since reset, saturating, so history checks start safely
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3: outputs are fully reduced whenever flagged valid
    a_r3_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (c0 < Q_W) && (c1 < Q_W));

    // R4: valid_out follows valid_in by exactly two edges
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (valid_out == $past(valid_in, 2)));

    // R6: outputs hold while no result is flagged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd2) && !valid_out) |-> ($stable(c0) && $stable(c1)));

    // R7: reset clears the valid flag and both results
    a_r7_reset: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && c0 == '0 && c1 == '0));
endmodule

bind bcm_basecase_mul bcm_basecase_mul_chk #(.Q(Q), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .valid_out (valid_out),
    .c0        (c0),
    .c1        (c1)
);

// File: tb/bcm_basecase_mul_bench.sv
`timescale 1ns/1ps
// Directed bench for bcm_basecase_mul: one task per scenario, integer model.
module bcm_basecase_mul_bench;
    localparam int Q    = 3329;
    localparam int W    = 12;
    localparam int MAXN = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [W-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0, zeta = '0;
    logic         valid_out;
    logic [W-1:0] c0, c1;

    int n_checks = 0;
    int n_errors = 0;

    int sa0 [MAXN];
    int sa1 [MAXN];
    int sb0 [MAXN];
    int sb1 [MAXN];
    int sz  [MAXN];
    bit sv  [MAXN];

    always #2.5 clk = ~clk;

    bcm_basecase_mul #(.Q(Q), .W(W)) u_bcm_basecase_mul (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .a0(a0), .a1(a1), .b0(b0), .b1(b1), .zeta(zeta),
        .valid_out(valid_out), .c0(c0), .c1(c1)
    );

    function automatic int model_c0(int x0, int x1, int y0, int y1, int z);
        return (x0 * y0 + ((x1 * y1) % Q) * z) % Q;
    endfunction

    function automatic int model_c1(int x0, int x1, int y0, int y1);
        return (x0 * y1 + x1 * y0) % Q;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stream the first n entries of the stimulus arrays and check each result
    task automatic run_stream(input int n, input string tag);
        int held0 = int'(c0);
        int held1 = int'(c1);
        for (int t = 0; t < n + 2; t++) begin
            @(negedge clk);
            if (t >= 2) begin
                int k = t - 2;
                check({tag, " R4 valid_out"}, int'(valid_out), int'(sv[k]));
                if (sv[k]) begin
                    held0 = model_c0(sa0[k], sa1[k], sb0[k], sb1[k], sz[k]);
                    held1 = model_c1(sa0[k], sa1[k], sb0[k], sb1[k]);
                    check({tag, " R1 c0"}, int'(c0), held0);
                    check({tag, " R2 c1"}, int'(c1), held1);
                    check({tag, " R3 c0 range"}, int'(c0 < W'(Q)), 1);
                end else begin
                    check({tag, " R6 c0 held"}, int'(c0), held0);
                    check({tag, " R6 c1 held"}, int'(c1), held1);
                end
            end
            if (t < n) begin
                valid_in = sv[t];
                a0 = W'(sa0[t]); a1 = W'(sa1[t]);
                b0 = W'(sb0[t]); b1 = W'(sb1[t]); zeta = W'(sz[t]);
            end else begin
                valid_in = 1'b0;
            end
        end
    endtask

    // Apply a single pair and return the outputs two edges later
    task automatic one_pair(input int x0, input int x1, input int y0, input int y1,
                            input int z, output int r0, output int r1);
        @(negedge clk);
        valid_in = 1'b1;
        a0 = W'(x0); a1 = W'(x1); b0 = W'(y0); b1 = W'(y1); zeta = W'(z);
        @(negedge clk);
        valid_in = 1'b0;
        @(negedge clk);
        check("R4 single valid_out", int'(valid_out), 1);
        r0 = int'(c0);
        r1 = int'(c1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 valid_out in reset", int'(valid_out), 0);
        check("R7 c0 in reset", int'(c0), 0);
        check("R7 c1 in reset", int'(c1), 0);
        valid_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_zeros();
        int r0, r1;
        one_pair(0, 0, 0, 0, 0, r0, r1);
        check("R1 zeros c0", r0, 0);
        check("R2 zeros c1", r1, 0);
    endtask

    task automatic t_max();
        int r0, r1;
        one_pair(Q-1, Q-1, Q-1, Q-1, Q-1, r0, r1);
        check("R3 max c0", r0, 0);
        check("R3 max c1", r1, 2);
    endtask

    task automatic t_zeta_one();
        int r0, r1;
        one_pair(1234, 3000, 2999, 17, 1, r0, r1);
        check("R8 zeta one c0", r0, (1234 * 2999 + 3000 * 17) % Q);
        check("R2 zeta one c1", r1, (1234 * 17 + 3000 * 2999) % Q);
    endtask

    task automatic t_hand();
        int r0, r1;
        one_pair(0, 1, 0, 1, 17, r0, r1);
        check("R1 X*X gives zeta", r0, 17);
        check("R2 X*X linear term", r1, 0);
        one_pair(1, 0, 5, 7, 17, r0, r1);
        check("R1 scalar times pair c0", r0, 5);
        check("R2 scalar times pair c1", r1, 7);
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < 40; i++) begin
            sa0[i] = int'($urandom % Q); sa1[i] = int'($urandom % Q);
            sb0[i] = int'($urandom % Q); sb1[i] = int'($urandom % Q);
            sz[i]  = int'($urandom % Q); sv[i]  = 1'b1;
        end
        run_stream(40, "R5 back-to-back");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 48; i++) begin
            sa0[i] = (i % 7 == 0) ? Q-1 : int'($urandom % Q);
            sa1[i] = int'($urandom % Q);
            sb0[i] = int'($urandom % Q);
            sb1[i] = (i % 5 == 0) ? Q-1 : int'($urandom % Q);
            sz[i]  = (i % 9 == 0) ? 1 : int'($urandom % Q);
            sv[i]  = (($urandom % 3) != 0);
        end
        run_stream(48, "gaps");
    endtask

    initial begin
        t_reset();
        t_zeros();
        t_max();
        t_zeta_one();
        t_hand();
        t_back_to_back();
        t_gaps();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule